// File: doc/BRIEF.md
# I2C Indexed Block Register Slave

This block is an I2C target holding a small byte-wide configuration register file. Every access is framed by an index and a byte count. A write carries the starting index, then a count, then that many data bytes, which land at consecutive indices. A read first sets the index in a short write phase and then issues a repeated START with the read address. The slave answers by sending the byte count as the first data byte, followed by register bytes from the index onward for as long as the host keeps acknowledging.

SCL and SDA are sampled through synchronizers clocked by a system clock that runs at least eight times the SCL rate. START and STOP are detected from the synchronized lines. SDA is driven open-drain: `sda_oe_o` high pulls the line low. The whole register file is also presented flat on `regs_o` for the logic that consumes the settings.

Top module: `i2c_idx_slave`

## Requirements
- R1: The slave acknowledges address byte 0xD2 (write) and 0xD3 (read), i.e. 7-bit address 0x69 with the R/W flag in bit 0. It leaves any other address byte unacknowledged and ignores the bus until the next START.
- R2: A write frame is: address, index N, count X, then data bytes stored at N, N+1, and so on. The slave acknowledges every byte in the address, index, count and data phases, where an acknowledge means SDA is low during the ninth SCL pulse.
- R3: Once X data bytes of a write frame have been stored, any further data byte is not acknowledged and is not stored. With X = 0 the first data byte is already refused.
- R4: On a read, after the repeated START and 0xD3, the first byte the slave sends is the count register at index 8. Register bytes from index N follow, one per host ACK.
- R5: The index is taken modulo 32, both from the index byte and when auto-incrementing. A frame that runs past index 31 continues at index 0.
- R6: Reserved bits are ignored on write and read back as 0. These are bits 1:0 of index 18 and all bits of indices 20 to 23.
- R7: After reset, every register is 0 except index 8, which is 8, and `sda_oe_o` is low.
- R8: A START in any state aborts the current frame, and the next byte is taken as an address. A STOP returns the slave to idle. Bytes already stored stay stored.
- R9: After the host NACKs a read byte, the slave releases SDA and stays off the bus until the next START. Outside START/STOP handling, `sda_oe_o` changes only while SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock, at least 8x the SCL rate |
| rst_ni | input | 1 | Asynchronous reset, active low |
| scl_i | input | 1 | I2C clock line |
| sda_i | input | 1 | I2C data line as seen on the pad |
| sda_oe_o | output | 1 | High pulls SDA low (open-drain) |
| regs_o | output | 256 | Register file, byte i at bits 8*i+7 : 8*i |

## Verification
The bench builds the block with its default parameters: 32 registers, a two-stage synchronizer, address 0x69, and the count register at index 8 with reset value 8. With 32 entries the wrap from index 31 to 0 can be reached, by a block write that starts at 30 and by an index byte of 42. The reserved entries at 18 and 20 to 23 sit inside the same file, so their masking is exercised alongside ordinary bytes. The host model runs SCL at ten system clocks per half period, which leaves room for the synchronizer delay before each sample point.

// File: rtl/i2c_idx_pkg.sv
package i2c_idx_pkg;
  typedef enum logic [2:0] {S_IDLE, S_RX, S_ACK, S_TX, S_MACK} state_e;
  typedef enum logic [1:0] {P_ADDR, P_INDEX, P_COUNT, P_DATA} phase_e;
endpackage

// File: rtl/i2c_idx_sync.sv
module i2c_idx_sync #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_o,
  output logic sda_o,
  output logic scl_rise_o,
  output logic scl_fall_o,
  output logic start_o,
  output logic stop_o
);
  localparam int W = SYNC_STAGES + 1;

  logic [W-1:0] scl_sh, sda_sh;
  logic scl_q, sda_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scl_sh <= '1;
      sda_sh <= '1;
    end else begin
      scl_sh <= {scl_sh[W-2:0], scl_i};
      sda_sh <= {sda_sh[W-2:0], sda_i};
    end
  end

  assign scl_o = scl_sh[SYNC_STAGES-1];
  assign sda_o = sda_sh[SYNC_STAGES-1];
  assign scl_q = scl_sh[SYNC_STAGES];
  assign sda_q = sda_sh[SYNC_STAGES];

  assign scl_rise_o = scl_o & ~scl_q;
  assign scl_fall_o = ~scl_o & scl_q;
  assign start_o    = scl_o & scl_q & sda_q & ~sda_o;
  assign stop_o     = scl_o & scl_q & ~sda_q & sda_o;
endmodule

// File: rtl/i2c_idx_fsm.sv
module i2c_idx_fsm
  import i2c_idx_pkg::*;
#(
  parameter logic [6:0] ADDR7 = 7'h69,
  parameter int AW = 5,
  parameter int DW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          scl_s_i,
  input  logic          sda_s_i,
  input  logic          scl_rise_i,
  input  logic          scl_fall_i,
  input  logic          start_i,
  input  logic          stop_i,
  input  logic [DW-1:0] rdata_i,
  input  logic [DW-1:0] cnt_i,
  output logic          we_o,
  output logic [AW-1:0] waddr_o,
  output logic [DW-1:0] wdata_o,
  output logic [AW-1:0] raddr_o,
  output logic          sda_oe_o
);
  state_e        state;
  phase_e        phase;
  logic [DW-1:0] sh;
  logic [3:0]    bit_cnt;
  logic [AW-1:0] idx;
  logic [DW-1:0] rem;
  logic          is_read;
  logic          oe_q;
  logic          byte_done;

  assign byte_done = (state == S_RX) && scl_fall_i && (bit_cnt == 4'd8);
  assign we_o      = byte_done && (phase == P_DATA) && (rem != '0);
  assign waddr_o   = idx;
  assign wdata_o   = sh;
  assign raddr_o   = idx;
  assign sda_oe_o  = oe_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state   <= S_IDLE;
      phase   <= P_ADDR;
      sh      <= '0;
      bit_cnt <= '0;
      idx     <= '0;
      rem     <= '0;
      is_read <= 1'b0;
      oe_q    <= 1'b0;
    end else if (start_i) begin
      state   <= S_RX;
      phase   <= P_ADDR;
      bit_cnt <= '0;
      is_read <= 1'b0;
      oe_q    <= 1'b0;
    end else if (stop_i) begin
      state <= S_IDLE;
      oe_q  <= 1'b0;
    end else begin
      unique case (state)
        S_IDLE: ;
        S_RX: begin
          if (scl_rise_i && bit_cnt != 4'd8) begin
            sh      <= {sh[DW-2:0], sda_s_i};
            bit_cnt <= bit_cnt + 4'd1;
          end
          if (byte_done) begin
            unique case (phase)
              P_ADDR: begin
                if (sh == {ADDR7, 1'b0}) begin
                  oe_q <= 1'b1; state <= S_ACK; phase <= P_INDEX; is_read <= 1'b0;
                end else if (sh == {ADDR7, 1'b1}) begin
                  oe_q <= 1'b1; state <= S_ACK; is_read <= 1'b1;
                end else begin
                  state <= S_IDLE;
                end
              end
              P_INDEX: begin
                idx <= sh[AW-1:0];
                oe_q <= 1'b1; state <= S_ACK; phase <= P_COUNT;
              end
              P_COUNT: begin
                rem <= sh;
                oe_q <= 1'b1; state <= S_ACK; phase <= P_DATA;
              end
              P_DATA: begin
                if (rem != '0) begin
                  rem  <= rem - 1'b1;
                  idx  <= idx + 1'b1;
                  oe_q <= 1'b1;
                  state <= S_ACK;
                end else begin
                  state <= S_IDLE;  // count exhausted: refuse
                end
              end
              default: state <= S_IDLE;
            endcase
          end
        end
        S_ACK: begin
          if (scl_fall_i) begin
            bit_cnt <= '0;
            if (is_read) begin
              sh    <= cnt_i;  // count byte leads every read
              oe_q  <= ~cnt_i[DW-1];
              state <= S_TX;
            end else begin
              oe_q  <= 1'b0;
              state <= S_RX;
            end
          end
        end
        S_TX: begin
          if (scl_rise_i) bit_cnt <= bit_cnt + 4'd1;
          if (scl_fall_i) begin
            if (bit_cnt == 4'd8) begin
              oe_q  <= 1'b0;
              state <= S_MACK;
            end else begin
              sh   <= {sh[DW-2:0], 1'b0};
              oe_q <= ~sh[DW-2];
            end
          end
        end
        S_MACK: begin
          if (scl_rise_i && sda_s_i) begin
            state <= S_IDLE;  // host NACK
          end else if (scl_fall_i) begin
            sh      <= rdata_i;
            oe_q    <= ~rdata_i[DW-1];
            idx     <= idx + 1'b1;
            bit_cnt <= '0;
            state   <= S_TX;
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  p_start_to_addr_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> (state == S_RX && phase == P_ADDR && bit_cnt == 4'd0 && !oe_q));

  p_idle_quiet_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state == S_IDLE) |-> !sda_oe_o);

  p_oe_scl_low_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!$stable(sda_oe_o) && !$past(start_i) && !$past(stop_i)) |-> !scl_s_i);

  p_idx_inc_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_o |=> (waddr_o == $past(waddr_o) + 1'b1));

  p_write_needs_ack_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_o |=> sda_oe_o);
endmodule

// File: rtl/i2c_idx_regfile.sv
module i2c_idx_regfile #(
  parameter int         NREG      = 32,
  parameter int         DW        = 8,
  parameter int         CNT_IDX   = 8,
  parameter logic [7:0] CNT_RST   = 8'd8,
  parameter int         PART_IDX  = 18,
  parameter logic [7:0] PART_MASK = 8'hFC,
  parameter int         RSVD_LO   = 20,
  parameter int         RSVD_HI   = 23,
  localparam int        AW        = $clog2(NREG)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [AW-1:0]    waddr_i,
  input  logic [DW-1:0]    wdata_i,
  input  logic [AW-1:0]    raddr_i,
  output logic [DW-1:0]    rdata_o,
  output logic [DW-1:0]    cnt_o,
  output logic [NREG*DW-1:0] regs_o
);
  logic [DW-1:0] mem [NREG];

  function automatic logic [DW-1:0] wmask(int i);
    if (i >= RSVD_LO && i <= RSVD_HI) return '0;
    if (i == PART_IDX) return DW'(PART_MASK);
    return '1;
  endfunction

  for (genvar i = 0; i < NREG; i++) begin : g_reg
    localparam logic [DW-1:0] MASK = wmask(i);
    localparam logic [DW-1:0] RSTV = (i == CNT_IDX) ? (DW'(CNT_RST) & MASK) : '0;

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                 mem[i] <= RSTV;
      else if (we_i && waddr_i == AW'(i))          mem[i] <= wdata_i & MASK;
    end

    assign regs_o[i*DW +: DW] = mem[i];

    p_masked_store_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (we_i && waddr_i == AW'(i)) |=> (mem[i] == ($past(wdata_i) & MASK)));
  end

  assign rdata_o = mem[raddr_i];
  assign cnt_o   = mem[CNT_IDX];
endmodule

// File: rtl/i2c_idx_slave.sv
module i2c_idx_slave #(
  parameter logic [6:0] ADDR7       = 7'h69,
  parameter int         NREG        = 32,
  parameter int         CNT_IDX     = 8,
  parameter logic [7:0] CNT_RST     = 8'd8,
  parameter int         SYNC_STAGES = 2,
  localparam int        DW          = 8,
  localparam int        AW          = $clog2(NREG)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               scl_i,
  input  logic               sda_i,
  output logic               sda_oe_o,
  output logic [NREG*DW-1:0] regs_o
);
  logic scl_s, sda_s, scl_rise, scl_fall, start, stop;
  logic we;
  logic [AW-1:0] waddr, raddr;
  logic [DW-1:0] wdata, rdata, cnt;

  i2c_idx_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
    .clk_i, .rst_ni, .scl_i, .sda_i,
    .scl_o(scl_s), .sda_o(sda_s), .scl_rise_o(scl_rise), .scl_fall_o(scl_fall),
    .start_o(start), .stop_o(stop)
  );

  i2c_idx_fsm #(.ADDR7(ADDR7), .AW(AW), .DW(DW)) u_fsm (
    .clk_i, .rst_ni,
    .scl_s_i(scl_s), .sda_s_i(sda_s), .scl_rise_i(scl_rise), .scl_fall_i(scl_fall),
    .start_i(start), .stop_i(stop), .rdata_i(rdata), .cnt_i(cnt),
    .we_o(we), .waddr_o(waddr), .wdata_o(wdata), .raddr_o(raddr), .sda_oe_o
  );

  i2c_idx_regfile #(.NREG(NREG), .DW(DW), .CNT_IDX(CNT_IDX), .CNT_RST(CNT_RST)) u_regs (
    .clk_i, .rst_ni, .we_i(we), .waddr_i(waddr), .wdata_i(wdata), .raddr_i(raddr),
    .rdata_o(rdata), .cnt_o(cnt), .regs_o
  );
endmodule

// File: tb/i2c_idx_slave_tb.sv
module i2c_idx_slave_tb;
  localparam int HP = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl = 1'b1;
  logic host_low = 1'b0;
  logic sda_line;
  logic sda_oe;
  logic [255:0] regs;

  int total = 0;
  int bad = 0;

  logic [7:0] wbuf [8];
  logic       wack [8];
  logic [7:0] rbuf [8];
  logic       addr_ack;
  logic [7:0] rcnt;

  always #2 clk = ~clk;
  assign sda_line = ~(host_low | sda_oe);

  i2c_idx_slave u_dut (
    .clk_i(clk), .rst_ni(rst_n), .scl_i(scl), .sda_i(sda_line),
    .sda_oe_o(sda_oe), .regs_o(regs)
  );

  // {index byte, written value, expected readback}
  localparam logic [23:0] VEC [8] = '{
    {8'h00, 8'hA5, 8'hA5},
    {8'h01, 8'h3C, 8'h3C},
    {8'h12, 8'hFF, 8'hFC},
    {8'h14, 8'hFF, 8'h00},
    {8'h17, 8'h81, 8'h00},
    {8'h13, 8'h5A, 8'h5A},
    {8'h1F, 8'hC3, 8'hC3},
    {8'h2A, 8'h77, 8'h77}
  };

  task automatic wt(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] reg_at(input int i);
    return regs[i*8 +: 8];
  endfunction

  task automatic i2c_start();
    host_low = 1'b0; wt(HP);
    scl = 1'b1; wt(HP);
    host_low = 1'b1; wt(HP);
    scl = 1'b0; wt(2);
  endtask

  task automatic i2c_stop();
    host_low = 1'b1; wt(HP);
    scl = 1'b1; wt(HP);
    host_low = 1'b0; wt(HP);
  endtask

  task automatic send_byte(input logic [7:0] b, output logic ackd);
    for (int i = 7; i >= 0; i--) begin
      host_low = ~b[i]; wt(HP);
      scl = 1'b1; wt(HP);
      scl = 1'b0; wt(2);
    end
    host_low = 1'b0; wt(HP);
    scl = 1'b1; wt(HP/2);
    ackd = ~sda_line; wt(HP/2);
    scl = 1'b0; wt(2);
  endtask

  task automatic recv_byte(input logic nack, output logic [7:0] b);
    host_low = 1'b0;
    for (int i = 7; i >= 0; i--) begin
      wt(HP);
      scl = 1'b1; wt(HP/2);
      b[i] = sda_line; wt(HP/2);
      scl = 1'b0; wt(2);
    end
    host_low = ~nack; wt(HP);
    scl = 1'b1; wt(HP);
    scl = 1'b0; wt(2);
    host_low = 1'b0;
  endtask

  task automatic wr_txn(input logic [7:0] idx, input logic [7:0] cnt, input int n);
    logic a;
    i2c_start();
    send_byte(8'hD2, addr_ack);
    send_byte(idx, a);
    check("R2 index ack", a, 1'b1);
    send_byte(cnt, a);
    check("R2 count ack", a, 1'b1);
    for (int k = 0; k < n; k++) send_byte(wbuf[k], wack[k]);
    i2c_stop();
  endtask

  task automatic rd_txn(input logic [7:0] idx, input int n);
    logic a;
    i2c_start();
    send_byte(8'hD2, a);
    send_byte(idx, a);
    i2c_start();
    send_byte(8'hD3, addr_ack);
    recv_byte(1'b0, rcnt);
    for (int k = 0; k < n; k++) recv_byte(k == n - 1, rbuf[k]);
    check("R9 released after host NACK", sda_oe, 1'b0);
    i2c_stop();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    wt(5);
    // R7 reset state
    check("R7 oe at reset", sda_oe, 1'b0);
    check("R7 count reg reset", reg_at(8), 8'd8);
    check("R7 reg0 reset", reg_at(0), 8'd0);
    rst_n = 1'b1;
    wt(5);

    // table: single byte write then read back
    for (int v = 0; v < 8; v++) begin
      wbuf[0] = VEC[v][15:8];
      wr_txn(VEC[v][23:16], 8'd1, 1);
      check("R1 write addr ack", addr_ack, 1'b1);
      check("R2 data ack", wack[0], 1'b1);
      check("R6 R5 stored value", reg_at(int'(VEC[v][20:16])), VEC[v][7:0]);
      rd_txn(VEC[v][23:16], 1);
      check("R1 read addr ack", addr_ack, 1'b1);
      check("R4 count byte", rcnt, 8'd8);
      check("R4 R6 readback", rbuf[0], VEC[v][7:0]);
    end

    // R2 block write, R4 block read
    wbuf[0] = 8'h11; wbuf[1] = 8'h22; wbuf[2] = 8'h33; wbuf[3] = 8'h44;
    wr_txn(8'd2, 8'd4, 4);
    for (int k = 0; k < 4; k++) check("R2 block ack", wack[k], 1'b1);
    rd_txn(8'd2, 4);
    check("R4 block count", rcnt, 8'd8);
    for (int k = 0; k < 4; k++) check("R4 block data", rbuf[k], wbuf[k]);

    // R5 wrap past 31
    wbuf[0] = 8'hE1; wbuf[1] = 8'hE2; wbuf[2] = 8'hE3;
    wr_txn(8'd30, 8'd3, 3);
    check("R5 wrap idx30", reg_at(30), 8'hE1);
    check("R5 wrap idx31", reg_at(31), 8'hE2);
    check("R5 wrap idx0", reg_at(0), 8'hE3);
    rd_txn(8'd31, 2);
    check("R5 read wrap a", rbuf[0], 8'hE2);
    check("R5 read wrap b", rbuf[1], 8'hE3);

    // R3 excess bytes refused
    wbuf[0] = 8'h55; wbuf[1] = 8'h66;
    wr_txn(8'd4, 8'd1, 2);
    check("R3 first ack", wack[0], 1'b1);
    check("R3 excess nack", wack[1], 1'b0);
    check("R3 stored", reg_at(4), 8'h55);
    check("R3 not stored", reg_at(5), 8'h44);
    wbuf[0] = 8'h99;
    wr_txn(8'd6, 8'd0, 1);
    check("R3 zero count nack", wack[0], 1'b0);
    check("R3 zero count untouched", reg_at(6), 8'h00);

    // R1 foreign address ignored
    begin
      logic a;
      i2c_start();
      send_byte(8'hA4, a);
      check("R1 foreign nack", a, 1'b0);
      send_byte(8'h01, a);
      check("R1 ignored index", a, 1'b0);
      send_byte(8'h00, a);
      check("R1 ignored byte", a, 1'b0);
      i2c_stop();
      check("R1 reg1 untouched", reg_at(1), 8'h3C);
    end

    // R4 count register drives read count
    wbuf[0] = 8'h03;
    wr_txn(8'd8, 8'd1, 1);
    rd_txn(8'd0, 2);
    check("R4 written count", rcnt, 8'h03);
    check("R4 data after count", rbuf[0], 8'hE3);

    // R8 STOP mid-frame, then fresh frame
    begin
      logic a;
      i2c_start();
      send_byte(8'hD2, a);
      send_byte(8'h09, a);
      i2c_stop();
      wbuf[0] = 8'h9C;
      wr_txn(8'd9, 8'd1, 1);
      check("R8 after stop ack", addr_ack, 1'b1);
      check("R8 after stop write", reg_at(9), 8'h9C);

      // START aborts a frame in progress
      i2c_start();
      send_byte(8'hD2, a);
      send_byte(8'd11, a);
      send_byte(8'd2, a);
      send_byte(8'h01, a);
      i2c_start();
      send_byte(8'hD2, a);
      check("R8 restart addr ack", a, 1'b1);
      send_byte(8'd12, a);
      send_byte(8'd1, a);
      send_byte(8'h7E, a);
      i2c_stop();
      check("R8 kept before abort", reg_at(11), 8'h01);
      check("R8 new frame write", reg_at(12), 8'h7E);
      check("R8 idle after stop", sda_oe, 1'b0);
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule